// File: doc/BRIEF.md
# Seconds Counter with Match Interrupt

This block keeps wall-clock time as a plain binary count of seconds. A 32-bit counter advances by one on every cycle where the once-per-second tick enable is high. Software can load the counter directly. A second 32-bit register holds an alarm time. When the counter and the alarm become equal, an interrupt is latched, and it stays latched until software clears it. Both registers are reached through a small register port: a select bit picks the register, a write strobe carries write data, and read data always shows the selected register.

Only the power-on reset initialises the block. A user reset input reaches the block, and it leaves the counter, the alarm and the interrupt untouched, so time survives a soft reset. The interrupt is managed by a two-state machine. In IRQ_IDLE the output is low. The transition IDLE_TO_PEND fires when equality newly appears, and the machine then sits in IRQ_PEND with the output high. The transition PEND_TO_IDLE fires on a clear, unless equality newly appears in that same cycle, in which case the machine stays in IRQ_PEND. Power-on reset forces IRQ_IDLE.

Top module: `rtc_secs_match`

## Requirements
- R1: While por_n is low, the counter reads 0, the alarm reads 0 and irq is 0.
- R2: A cycle with tick=1 and no counter write adds 1 to the counter. 0xFFFFFFFF becomes 0, and the wrap by itself raises no interrupt.
- R3: A write with sel=0 loads wr_data into the counter at that clock edge. If tick is also high in that cycle, the loaded value is kept unincremented, and the next tick adds 1.
- R4: A write with sel=1 loads wr_data into the alarm register. Nothing else changes the alarm, and ticks in particular do not.
- R5: rd_data shows the counter when sel=0 and the alarm when sel=1, in the same cycle. Reads change no state.
- R6: When counter==alarm holds in a cycle and did not hold in the previous cycle, irq goes to 1 at the next clock edge. This holds whether the equality came from a tick, a counter write or an alarm write. Equality that already holds when power-on reset ends does not raise irq.
- R7: Once set, irq stays at 1 until a cycle with irq_clr=1, which returns it to 0. Equality that continues after the clear does not raise it again. If a new equality appears in the same cycle as the clear, irq stays at 1.
- R8: usr_rst_n has no effect on the counter, the alarm or irq.
- R9: With no tick and no counter write, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| usr_rst_n | input | 1 | User reset, active low, ignored by this block |
| tick | input | 1 | One-second enable pulse, one clock wide |
| sel | input | 1 | Register select: 0 counter, 1 alarm |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| irq_clr | input | 1 | Clears the latched interrupt |
| irq | output | 1 | Latched match interrupt |

## Verification
The assertions assume that tick, wr_en, sel, wr_data and irq_clr are synchronous to clk and settle before each rising edge. They also assume that por_n is held low long enough to initialise every register before any stimulus is applied. The bench changes every input only on the falling edge of the clock and checks outputs on the falling edge as well. It keeps all activity inside a single power-on period after the first reset. User reset is driven only while ticks and register traffic go on, so that any effect it had would appear in the values read back.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned TIME_W = 32;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;

    localparam logic SEL_COUNT = 1'b0;
    localparam logic SEL_ALARM = 1'b1;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (tick) begin
            cnt_d = cnt_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

    // R2: tick without write advances by one (wrapping)
    p_tick_adds_one_r2: assert property (@(posedge clk) disable iff (!por_n)
        (tick && !load) |=> (cnt_q == $past(cnt_q) + ONE));

    // R3: write wins over a coincident tick
    p_load_wins_r3: assert property (@(posedge clk) disable iff (!por_n)
        load |=> (cnt_q == $past(load_val)));

    // R9: idle cycles hold the count
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_alarm_reg.sv
module rtc_alarm_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] alarm
);
    logic [W-1:0] alm_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            alm_q <= '0;
        end else if (load) begin
            alm_q <= load_val;
        end
    end

    assign alarm = alm_q;

    p_alarm_load_r4: assert property (@(posedge clk) disable iff (!por_n)
        load |=> (alm_q == $past(load_val)));

    p_alarm_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
        !load |=> $stable(alm_q));
endmodule

// File: rtl/rtc_irq_fsm.sv
module rtc_irq_fsm
    import rtc_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] count,
    input  logic [W-1:0] alarm,
    input  logic         clr,
    output logic         irq
);
    irq_state_e state_q;
    irq_state_e state_d;
    logic       eq;
    logic       eq_prev_q;
    logic       eq_rise;

    assign eq      = (count == alarm);
    assign eq_rise = eq && !eq_prev_q;

    // equality seen at reset counts as old, so it cannot raise irq
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            eq_prev_q <= 1'b1;
        end else begin
            eq_prev_q <= eq;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (eq_rise)         state_d = IRQ_PEND;  // IDLE_TO_PEND
            IRQ_PEND: if (clr && !eq_rise) state_d = IRQ_IDLE;  // PEND_TO_IDLE
            default:                       state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            IRQ_IDLE: irq = 1'b0;
            IRQ_PEND: irq = 1'b1;
            default:  irq = 1'b0;
        endcase
    end

    p_rise_sets_r6: assert property (@(posedge clk) disable iff (!por_n)
        eq_rise |=> irq);

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!irq && !eq_rise) |=> !irq);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
        (irq && !clr) |=> irq);

    p_clear_r7: assert property (@(posedge clk) disable iff (!por_n)
        (irq && clr && !eq_rise) |=> !irq);
endmodule

// File: rtl/rtc_secs_match.sv
module rtc_secs_match
    import rtc_pkg::*;
#(
    parameter int unsigned W = TIME_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         usr_rst_n,
    input  logic         tick,
    input  logic         sel,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         irq_clr,
    output logic         irq
);
    logic [W-1:0] count;
    logic [W-1:0] alarm;
    logic         ld_count;
    logic         ld_alarm;

    assign ld_count = wr_en && (sel == SEL_COUNT);
    assign ld_alarm = wr_en && (sel == SEL_ALARM);

    rtc_sec_counter #(.W(W)) u_counter (
        .clk      (clk),
        .por_n    (por_n),
        .tick     (tick),
        .load     (ld_count),
        .load_val (wr_data),
        .count    (count)
    );

    rtc_alarm_reg #(.W(W)) u_alarm (
        .clk      (clk),
        .por_n    (por_n),
        .load     (ld_alarm),
        .load_val (wr_data),
        .alarm    (alarm)
    );

    rtc_irq_fsm #(.W(W)) u_irq (
        .clk   (clk),
        .por_n (por_n),
        .count (count),
        .alarm (alarm),
        .clr   (irq_clr),
        .irq   (irq)
    );

    assign rd_data = (sel == SEL_ALARM) ? alarm : count;

    // R8: user reset alone leaves the visible state unchanged
    p_usr_rst_inert_r8: assert property (@(posedge clk) disable iff (!por_n)
        (!usr_rst_n && !tick && !wr_en && !irq_clr) |=>
            ($stable(count) && $stable(alarm)));

    // R1: reset values while power-on reset is asserted
    always_comb begin
        if (!por_n) begin
            p_por_values_r1: assert (count == '0 && alarm == '0 && !irq);
        end
    end
endmodule

// File: tb/rtc_secs_match_tb.sv
module rtc_secs_match_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        usr_rst_n = 1'b1;
    logic        tick = 1'b0;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_clr = 1'b0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rtc_secs_match u_dut (
        .clk(clk), .por_n(por_n), .usr_rst_n(usr_rst_n), .tick(tick),
        .sel(sel), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq_clr(irq_clr), .irq(irq)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%h expected=%h", what, got, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr(input logic s, input logic [31:0] d);
        sel = s; wr_en = 1'b1; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic tk();
        tick = 1'b1;
        cyc();
        tick = 1'b0;
    endtask

    function automatic logic [31:0] rd(input logic s);
        return 32'(s ? u_dut.rd_data : u_dut.rd_data);
    endfunction

    task automatic rdc(input logic s, output logic [31:0] v);
        sel = s;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        repeat (3) cyc();
        rdc(1'b0, v); chk("R1 count at reset", v, 32'h0);
        rdc(1'b1, v); chk("R1 alarm at reset", v, 32'h0);
        chk("R1 irq at reset", {31'b0, irq}, 32'h0);
        por_n = 1'b1;
        repeat (3) cyc();
        chk("R6 no irq from equality present at reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_tick_count();
        logic [31:0] v;
        wr(1'b1, 32'd1000);
        wr(1'b0, 32'd100);
        repeat (3) tk();
        rdc(1'b0, v); chk("R2 three ticks", v, 32'd103);
        repeat (5) cyc();
        rdc(1'b0, v); chk("R9 idle hold", v, 32'd103);
        rdc(1'b1, v); chk("R4 alarm unchanged by ticks", v, 32'd1000);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        sel = 1'b0; wr_en = 1'b1; wr_data = 32'd500; tick = 1'b1;
        cyc();
        wr_en = 1'b0; tick = 1'b0;
        rdc(1'b0, v); chk("R3 write beats tick", v, 32'd500);
        tk();
        rdc(1'b0, v); chk("R3 next tick increments", v, 32'd501);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(1'b1, 32'd5);
        wr(1'b0, 32'hFFFF_FFFF);
        tk();
        rdc(1'b0, v); chk("R2 wrap to zero", v, 32'h0);
        cyc(); cyc();
        chk("R2 wrap raises no irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_irq_tick();
        wr(1'b1, 32'd10);
        wr(1'b0, 32'd8);
        tk();
        tk();
        chk("R6 irq not yet at match edge", {31'b0, irq}, 32'h0);
        cyc();
        chk("R6 irq set after tick match", {31'b0, irq}, 32'h1);
        repeat (4) cyc();
        tk();
        cyc();
        chk("R7 irq sticky", {31'b0, irq}, 32'h1);
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        chk("R7 irq cleared", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_clear_while_equal();
        wr(1'b0, 32'd20);
        cyc();
        chk("R6 no irq without equality", {31'b0, irq}, 32'h0);
        wr(1'b1, 32'd20);
        cyc();
        chk("R6 irq from alarm write", {31'b0, irq}, 32'h1);
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        repeat (3) cyc();
        chk("R7 persistent equality no re-raise", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_clear_collision();
        wr(1'b1, 32'd40);
        wr(1'b0, 32'd40);
        cyc();
        chk("R6 irq from counter write", {31'b0, irq}, 32'h1);
        wr(1'b1, 32'd42);
        tk();
        tk();
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        chk("R7 new match beats clear", {31'b0, irq}, 32'h1);
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
        chk("R7 later clear works", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_user_reset();
        logic [31:0] v;
        wr(1'b1, 32'd300);
        wr(1'b0, 32'd298);
        usr_rst_n = 1'b0;
        tk();
        tk();
        repeat (2) cyc();
        rdc(1'b0, v); chk("R8 count under user reset", v, 32'd300);
        rdc(1'b1, v); chk("R8 alarm under user reset", v, 32'd300);
        chk("R8 irq under user reset", {31'b0, irq}, 32'h1);
        usr_rst_n = 1'b1;
        irq_clr = 1'b1; cyc(); irq_clr = 1'b0;
    endtask

    task automatic t_reads();
        logic [31:0] v;
        for (int i = 0; i < 6; i++) begin
            rdc(i[0], v);
            cyc();
        end
        rdc(1'b0, v); chk("R5 count after reads", v, 32'd300);
        rdc(1'b1, v); chk("R5 alarm after reads", v, 32'd300);
        chk("R5 irq after reads", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        cyc();
        t_reset();
        t_tick_count();
        t_collision();
        t_wrap();
        t_irq_tick();
        t_clear_while_equal();
        t_clear_collision();
        t_user_reset();
        t_reads();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule